// File: doc/BRIEF.md
# Two-Wire Serial Memory Page-Write Slave

This block is the write side of a two-wire serial memory slave. It watches the clock and data lines and finds START and STOP conditions. It matches a 7-bit device address and then accepts a word address sent as two bytes. After that it collects data bytes into a page buffer. The buffer holds one page of `2**PAGE_W` bytes. A load pointer steps through the page and wraps back to the start of the same page. The page number stays fixed for the whole load.

The buffered bytes reach the storage array only when the load ends with a well-formed STOP. That STOP must come after at least one data byte has been fully acknowledged. When the commit happens, the block raises `busy` for `WR_TICKS` clock cycles. While `busy` is high, everything on the bus is ignored, including the device's own address. A master can therefore poll with its address byte until it gets an acknowledge. Any other ending drops the buffered bytes and leaves the array as it was.

The slave drives the data line open-drain. `sda_oe` high means the line is pulled low. The storage array can be read by address through a plain combinational lookup port.

Top module: `eeprom_page_writer`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal `DEV_ADDR` gets an acknowledge on the ninth clock (the line is held low while SCL is high). This holds for the direction bit at 0 (write) and at 1 (read). Any other device address gets no acknowledge.
- R2: In a write transfer, the upper word-address byte, the lower word-address byte and every data byte are each acknowledged. `sda_oe` only changes while SCL is low.
- R3: A STOP that comes right after the acknowledge of one or more data bytes copies the loaded bytes into the array at the page chosen by the word address. `busy` rises in the cycle after that STOP is seen.
- R4: The low `PAGE_W` address bits count up and wrap within the page, and the upper bits stay fixed. With 64-byte pages, 12 bytes loaded from offset 60 land at offsets 60..63 and then 0..7 of the same page.
- R5: Only bytes actually loaded are written. Every other byte of the page, and of the array, keeps its old value.
- R6: A STOP in the middle of a data byte writes nothing and leaves `busy` low.
- R7: A STOP before the first data byte has been acknowledged (for example, right after the word address) writes nothing and leaves `busy` low.
- R8: After a commit, `busy` stays high for exactly `WR_TICKS` clock cycles.
- R9: While `busy` is high, the slave never acknowledges, the array does not change, and bus activity has no effect.
- R10: Once `busy` has fallen, the device address is acknowledged again for both write and read requests.
- R11: A repeated START during a page load throws away the bytes buffered so far. Only the bytes of the following, properly ended load are written.
- R12: After reset, `busy` and `sda_oe` are low and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low (open-drain acknowledge) |
| busy | output | 1 | Nonvolatile write cycle running |
| rd_addr | input | ADDR_W | Array lookup address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
A bad bit counter or a wrong phase flag shows up at once at the pins. An acknowledge appears one clock late or early, or a legal STOP is rejected. Either way, the master's next ninth-clock sample, or the `busy` level a few cycles after the STOP, reveals it within one byte time. A load pointer that leaves its page, or a mask that is not cleared on a discarded load, only shows after the next commit. The bench therefore reads back the whole array after each ending and compares it against a model it keeps itself. The length of the write cycle is counted edge by edge, so an off-by-one in the tick counter shows as a miscount of one cycle.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int WR_TICKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(WR_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA} state_t;

  logic [2:0]        scl_p, sda_p;
  state_t            state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              ack_q, busy_q;
  logic [HI_W-1:0]   ahi;
  logic [PG_W-1:0]   page;
  logic [PAGE_W-1:0] ptr;
  logic [CNT_W-1:0]  wcnt;
  logic [PAGE-1:0]   mask;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  wire scl_s = scl_p[1], scl_q = scl_p[2];
  wire sda_s = sda_p[1], sda_q = sda_p[2];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire stop_ok   = (state == S_DATA) && (|mask) && (bitcnt <= 4'd1) && !ack_q;
  wire commit    = !busy_q && stop_det && stop_ok;
  wire ack_done  = !busy_q && !start_det && !stop_det && (state != S_IDLE) && scl_fall && (bitcnt == 4'd9);

  assign sda_oe  = ack_q;
  assign busy    = busy_q;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
      ahi    <= '0;
      page   <= '0;
      ptr    <= '0;
      wcnt   <= '0;
      mask   <= '0;
    end else if (busy_q) begin
      if (wcnt == '0) busy_q <= 1'b0;
      else            wcnt   <= wcnt - 1'b1;
    end else if (start_det) begin
      state  <= S_DEV;
      bitcnt <= '0;
      ack_q  <= 1'b0;
      mask   <= '0;
    end else if (stop_det) begin
      if (stop_ok) begin
        busy_q <= 1'b1;
        wcnt   <= CNT_W'(WR_TICKS - 1);
      end
      state  <= S_IDLE;
      bitcnt <= '0;
      ack_q  <= 1'b0;
      mask   <= '0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (ack_q) begin
          bitcnt <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8 && !ack_q) begin
          if (state != S_DEV || shreg[7:1] == DEV_ADDR) ack_q <= 1'b1;
          else begin
            state  <= S_IDLE;
            bitcnt <= '0;
          end
        end else if (bitcnt == 4'd9) begin
          ack_q  <= 1'b0;
          bitcnt <= '0;
          case (state)
            S_DEV:  state <= shreg[0] ? S_IDLE : S_AHI;
            S_AHI: begin
              ahi   <= shreg[HI_W-1:0];
              state <= S_ALO;
            end
            S_ALO: begin
              {page, ptr} <= {ahi, shreg};
              state       <= S_DATA;
            end
            S_DATA: begin
              mask[ptr] <= 1'b1;
              ptr       <= ptr + 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end

  always_ff @(posedge clk)
    if (ack_done && state == S_DATA) pbuf[ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (mask[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
    end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R2
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R9
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wcnt != '0) |=> busy); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wcnt == '0) |=> !busy); // R8
  AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data)); // R9
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int WR = 300;
  localparam int AW = 10;
  localparam int Q  = 8;
  localparam logic [8:0] ADDR_VEC [6] = '{
    {8'hA0, 1'b1}, {8'hA1, 1'b1}, {8'hA2, 1'b0},
    {8'h20, 1'b0}, {8'hB0, 1'b0}, {8'hA3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sda_oe, busy;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, cyc = 0, busy_cycles = 0;
  logic [7:0] model [1 << AW];

  always #10 clk = ~clk;

  eeprom_page_writer #(.DEV_ADDR(7'h50), .ADDR_W(AW), .PAGE_W(6), .WR_TICKS(WR)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cycles++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    int act = 0, exp = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== model[a] && bad < 0) begin
        bad = a; act = rd_data; exp = model[a];
      end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s array byte %0h: actual=%0h expected=%0h", req, bad, act, exp);
    end
  endtask

  task automatic model_write(input logic [AW-1:0] addr, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      model[{addr[AW-1:6], 6'(addr[5:0] + i)}] = seed + 8'(i);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wt(Q);
    m_scl = 1'b1; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q / 2);
    ack = ~sda_line;
    wt(Q / 2);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic load(input logic [AW-1:0] addr, input int n, input logic [7:0] seed);
    logic ack;
    i2c_start;
    send_byte(8'hA0, ack);            chk("R1", "write address ack", ack, 1);
    send_byte(8'(addr >> 8), ack);    chk("R2", "upper word address ack", ack, 1);
    send_byte(addr[7:0], ack);        chk("R2", "lower word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i), ack);   chk("R2", "data byte ack", ack, 1);
    end
  endtask

  task automatic commit(input logic [AW-1:0] addr, input int n, input logic [7:0] seed, input string req);
    busy_cycles = 0;
    i2c_stop;
    chk("R3", "busy after valid stop", busy, 1);
    while (busy) wt(1);
    wt(2);
    chk("R8", "busy length", busy_cycles, WR);
    model_write(addr, n, seed);
    check_mem(req);
  endtask

  initial begin
    logic ack;
    for (int a = 0; a < (1 << AW); a++) model[a] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(10);
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "sda_oe after reset", sda_oe, 0);
    check_mem("R12");

    // R1: address match table
    for (int v = 0; v < 6; v++) begin
      i2c_start;
      send_byte(ADDR_VEC[v][8:1], ack);
      chk("R1", $sformatf("address byte %0h ack", ADDR_VEC[v][8:1]), ack, int'(ADDR_VEC[v][0]));
      i2c_stop;
      wt(Q);
    end

    load(10'h010, 4, 8'h11);
    commit(10'h010, 4, 8'h11, "R3");

    load(10'h040, 16, 8'hC0);
    commit(10'h040, 16, 8'hC0, "R5");

    // R4: 12 bytes from offset 60 of page 1 wrap to offsets 0..7
    load(10'h07C, 12, 8'h40);
    commit(10'h07C, 12, 8'h40, "R4");
    check_mem("R5");

    // R6: stop in the middle of a data byte
    load(10'h0A0, 2, 8'h55);
    for (int k = 0; k < 4; k++) send_bit(k[0]);
    i2c_stop; wt(20);
    chk("R6", "busy after mid-byte stop", busy, 0);
    check_mem("R6");

    // R7: stop before any data byte
    load(10'h0C0, 0, 8'h00);
    i2c_stop; wt(20);
    chk("R7", "busy after early stop", busy, 0);
    check_mem("R7");

    // R11: repeated start discards buffered bytes
    load(10'h030, 3, 8'h70);
    load(10'h038, 1, 8'h99);
    commit(10'h038, 1, 8'h99, "R11");

    // R9: inputs ignored while busy
    load(10'h100, 2, 8'h21);
    busy_cycles = 0;
    i2c_stop;
    chk("R3", "busy after valid stop", busy, 1);
    i2c_start;
    send_byte(8'hA0, ack);
    chk("R9", "address ack while busy", ack, 0);
    send_byte(8'h02, ack);
    chk("R9", "byte ack while busy", ack, 0);
    i2c_stop;
    while (busy) wt(1);
    wt(2);
    chk("R8", "busy length with bus traffic", busy_cycles, WR);
    model_write(10'h100, 2, 8'h21);
    check_mem("R9");

    // R10: acknowledge polling succeeds after the cycle
    i2c_start; send_byte(8'hA0, ack); chk("R10", "write poll ack", ack, 1); i2c_stop;
    i2c_start; send_byte(8'hA1, ack); chk("R10", "read poll ack", ack, 1); i2c_stop;
    wt(10);
    chk("R9", "no write from polling", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule